// File: doc/BRIEF.md
# Cascade Codec Configuration and Transfer Sequencer

This block sits on the host side of a serial link that feeds a daisy chain of codec channels. The far end of the chain returns one word per channel on each sample event. Each returned word carries a frame-sync pulse on its first bit. When the first word of a sample event begins, the block answers at once with one outgoing word per channel. The outgoing words follow each other with no idle bit between them. Because there is no gap, every channel in the chain latches its word in the same frame.

After reset the block spends three sample events on configuration. It sets the clocking register first, the power register second, and the mode register third. In each of these events every channel receives a control word for the same register. Once the mode register has gone out, a sticky done flag rises and the block moves into steady data transfer. In that state, each event sends the converter words that the user supplies for every channel. The block also hands back the received words, one per channel, each with a one-cycle valid pulse. Words are sent farthest-channel first and arrive farthest-channel first.

Top module: `casc_host`

## Requirements
- R1: After reset, `tx_fs`, `tx_sd`, `cfg_done` and `adc_valid` are low, and `adc_word` is all zeros.
- R2: A sample event starts when `rx_fs` is high and no earlier word of the current event is still expected. The cycle after that, `tx_fs` is high and `tx_sd` carries bit 15. The block then sends N_CH 16-bit words MSB first, back to back, with `tx_fs` high only on the MSB cycle of each word.
- R3: A control word is laid out as follows. Bit 15 = 1 (control). Bit 14 = 0 (write). Bits 13:11 = cascade address. Bits 10:8 = register index (mode register = 0, clock register = 1, power register = 2). Bits 7:0 = data. The word in send slot s carries address N_CH-1-s.
- R4: The first event after reset programs the clock register, the second programs the power register, and the third programs the mode register. Every word of one event addresses the same register.
- R5: The clock data is 0x1B: divider code 0 (ratio 1) in bits 7:5, serial-clock code 3 (master/2) in bits 4:3, and sample-rate code 3 (master/256) in bits 1:0. The power data is 0x07, which powers up the reference (bit 0), the ADC (bit 1) and the DAC (bit 2). The mode data has bit 7 = 1 (data mode) and the channel count N_CH in bits 2:0, giving 0x82 for two channels.
- R6: `cfg_done` rises in the cycle after the last bit of the mode-register event. It then stays high until reset.
- R7: In data events, send slot s carries `dac_word` of channel N_CH-s, sampled at the edge where that word is loaded. Channel k occupies bits [16k-1:16(k-1)].
- R8: Receive slot s belongs to channel N_CH-s. For a data event, the channel's `adc_word` field is updated and its `adc_valid` bit pulses for one cycle, W+1 cycles after that word's MSB cycle. At most one valid bit is high at a time.
- R9: Words received during configuration events produce no valid pulse and leave `adc_word` unchanged.
- R10: The next event's frame sync may arrive in the cycle right after the last received bit. Transmission then continues with no gap. The last received word of the previous event is still judged by that event's mode.
- R11: Each `rx_fs` pulse marks the MSB of a 16-bit received word. A pulse never arrives in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fs | input | 1 | Frame sync from the chain, high on each returned word's MSB |
| rx_sd | input | 1 | Serial data from the chain |
| tx_fs | output | 1 | Frame sync to the chain, high on each sent word's MSB |
| tx_sd | output | 1 | Serial data to the chain |
| dac_word | input | N_CH*16 | Converter words to send, one field per channel |
| adc_word | output | N_CH*16 | Last received data word, one field per channel |
| adc_valid | output | N_CH | One-cycle update pulse per channel |
| cfg_done | output | 1 | Sticky: configuration has completed |

## Verification
Two things can meet in one cycle. The first is the completion strobe of an event's final received word. The second is the frame sync that opens the next event, which also advances the configuration phase. The bench provokes this by following the mode-register event, and several data events, with zero idle cycles. It then judges that the last word of the mode event is still dropped, that the next event's words are delivered, and that the transmit stream keeps exact 16-cycle spacing across the boundary.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_CLK  = 2'd0,
    PH_PWR  = 2'd1,
    PH_MODE = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  localparam logic [2:0] RIDX_MODE = 3'd0;
  localparam logic [2:0] RIDX_CLK  = 3'd1;
  localparam logic [2:0] RIDX_PWR  = 3'd2;

  function automatic logic [WORD_W-1:0] ctrl_word(input logic [ADDR_W-1:0] addr,
                                                  input logic [2:0] ridx,
                                                  input logic [DATA_W-1:0] data);
    return {1'b1, 1'b0, addr, ridx, data};
  endfunction

  function automatic logic [2:0] phase_ridx(input phase_e ph);
    case (ph)
      PH_CLK:  return RIDX_CLK;
      PH_PWR:  return RIDX_PWR;
      default: return RIDX_MODE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mode_data(input int n_ch);
    return {1'b1, 4'b0000, 3'(n_ch)};
  endfunction

  function automatic phase_e phase_step(input phase_e ph);
    return (ph == PH_DATA) ? PH_DATA : phase_e'(ph + 2'd1);
  endfunction
endpackage

// File: rtl/casc_rx.sv
module casc_rx
  import casc_pkg::*;
#(
  parameter int N_CH = 2,
  localparam int SLOT_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              sd,
  output logic              ev_start,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic [SLOT_W-1:0] done_slot
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic [SLOT_W-1:0] next_slot, cur_slot;

  assign ev_start = fs && (next_slot == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      next_slot <= '0;
      cur_slot  <= '0;
      word_done <= 1'b0;
      word      <= '0;
      done_slot <= '0;
    end else begin
      word_done <= 1'b0;
      if (fs) begin
        sh        <= {sh[WORD_W-2:0], sd};
        cnt       <= CNT_W'(1);
        cur_slot  <= next_slot;
        next_slot <= (next_slot == SLOT_W'(N_CH - 1)) ? '0 : next_slot + 1'b1;
      end else if (cnt != '0) begin
        sh <= {sh[WORD_W-2:0], sd};
        if (cnt == CNT_W'(WORD_W - 1)) begin
          cnt       <= '0;
          word_done <= 1'b1;
          word      <= {sh[WORD_W-2:0], sd};
          done_slot <= cur_slot;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RX_FS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    fs |-> (cnt == '0)); // R11
  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R8
endmodule

// File: rtl/casc_tx.sv
module casc_tx
  import casc_pkg::*;
#(
  parameter int N_CH = 2,
  localparam int SLOT_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] load_word,
  output logic [SLOT_W-1:0] load_slot,
  output logic              ev_last,
  output logic              tx_fs,
  output logic              tx_sd
);
  logic [CNT_W-1:0]  left;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] sh;
  logic              word_end, more, do_load;

  assign word_end  = (left == CNT_W'(1));
  assign more      = (slot != SLOT_W'(N_CH - 1));
  assign do_load   = start || (word_end && more);
  assign load_slot = start ? '0 : slot + 1'b1;
  assign ev_last   = word_end && !more;
  assign tx_sd     = (left != '0) && sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      slot  <= '0;
      sh    <= '0;
      tx_fs <= 1'b0;
    end else begin
      tx_fs <= 1'b0;
      if (do_load) begin
        sh    <= load_word;
        left  <= CNT_W'(WORD_W);
        slot  <= load_slot;
        tx_fs <= 1'b1;
      end else if (left != '0) begin
        sh   <= {sh[WORD_W-2:0], 1'b0};
        left <= left - 1'b1;
      end
    end
  end

  AST_TX_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && more) |=> tx_fs); // R2
  AST_TX_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((left == '0) || (word_end && !more))); // R10
  AST_TX_FS_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |-> (left == CNT_W'(WORD_W))); // R2
endmodule

// File: rtl/casc_seq.sv
module casc_seq
  import casc_pkg::*;
#(
  parameter int N_CH = 2,
  parameter logic [DATA_W-1:0] CLK_DATA = 8'h1B,
  parameter logic [DATA_W-1:0] PWR_DATA = 8'h07,
  localparam int SLOT_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_start,
  input  logic                     ev_last,
  input  logic [SLOT_W-1:0]        load_slot,
  input  logic [N_CH*WORD_W-1:0]   dac_flat,
  output logic [WORD_W-1:0]        load_word,
  output phase_e                   ev_phase,
  output logic                     cfg_done
);
  phase_e phase, ph_use;

  function automatic logic [DATA_W-1:0] reg_data(input phase_e ph);
    case (ph)
      PH_CLK:  return CLK_DATA;
      PH_PWR:  return PWR_DATA;
      default: return mode_data(N_CH);
    endcase
  endfunction

  always_comb begin
    int idx;
    ph_use = ev_start ? phase : ev_phase;
    idx    = N_CH - 1 - int'(load_slot);
    if (ph_use == PH_DATA)
      load_word = dac_flat[idx*WORD_W +: WORD_W];
    else
      load_word = ctrl_word(ADDR_W'(idx), phase_ridx(ph_use), reg_data(ph_use));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_CLK;
      ev_phase <= PH_CLK;
      cfg_done <= 1'b0;
    end else begin
      if (ev_start) begin
        ev_phase <= phase;
        phase    <= phase_step(phase);
      end
      if (ev_last && ev_phase == PH_MODE)
        cfg_done <= 1'b1;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_start |=> $stable(phase)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done); // R6
  AST_DONE_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> ($past(ev_phase) == PH_MODE)); // R6
endmodule

// File: rtl/casc_host.sv
module casc_host
  import casc_pkg::*;
#(
  parameter int N_CH = 2,
  parameter logic [7:0] CLK_DATA = 8'h1B,
  parameter logic [7:0] PWR_DATA = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_fs,
  input  logic                   rx_sd,
  output logic                   tx_fs,
  output logic                   tx_sd,
  input  logic [N_CH*16-1:0]     dac_word,
  output logic [N_CH*16-1:0]     adc_word,
  output logic [N_CH-1:0]        adc_valid,
  output logic                   cfg_done
);
  localparam int SLOT_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic              ev_start, word_done, ev_last;
  logic [WORD_W-1:0] rx_word, load_word;
  logic [SLOT_W-1:0] done_slot, load_slot;
  phase_e            ev_phase;

  casc_rx #(.N_CH(N_CH)) u_rx (
    .clk(clk), .rst_n(rst_n), .fs(rx_fs), .sd(rx_sd),
    .ev_start(ev_start), .word_done(word_done), .word(rx_word), .done_slot(done_slot)
  );

  casc_tx #(.N_CH(N_CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .load_word(load_word),
    .load_slot(load_slot), .ev_last(ev_last), .tx_fs(tx_fs), .tx_sd(tx_sd)
  );

  casc_seq #(.N_CH(N_CH), .CLK_DATA(CLK_DATA), .PWR_DATA(PWR_DATA)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_last(ev_last),
    .load_slot(load_slot), .dac_flat(dac_word), .load_word(load_word),
    .ev_phase(ev_phase), .cfg_done(cfg_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_word  <= '0;
      adc_valid <= '0;
    end else begin
      adc_valid <= '0;
      if (word_done && ev_phase == PH_DATA) begin
        adc_word[(N_CH - 1 - int'(done_slot))*WORD_W +: WORD_W] <= rx_word;
        adc_valid[N_CH - 1 - int'(done_slot)] <= 1'b1;
      end
    end
  end

  AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_valid)); // R8
  AST_CFG_WORDS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_valid != '0) |-> cfg_done); // R9
  AST_ADC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_valid == '0) |-> $stable(adc_word)); // R9
endmodule

// File: tb/casc_host_tb.sv
module casc_host_tb;
  localparam int N = 2;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_fs = 1'b0, rx_sd = 1'b0;
  logic tx_fs, tx_sd, cfg_done;
  logic [N*W-1:0] dac_word = '0;
  logic [N*W-1:0] adc_word;
  logic [N-1:0] adc_valid;

  always #2 clk = ~clk;

  casc_host #(.N_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_fs(rx_fs), .rx_sd(rx_sd),
    .tx_fs(tx_fs), .tx_sd(tx_sd), .dac_word(dac_word),
    .adc_word(adc_word), .adc_valid(adc_valid), .cfg_done(cfg_done)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  int          txc_q[$], exp_txc[$];
  logic [15:0] txw_q[$], exp_txw[$];
  int          ac_q[$], ach_q[$], exp_ac[$], exp_ach[$];
  logic [15:0] aw_q[$], exp_aw[$];
  int          done_cyc = -1, exp_done = -1;
  int          ev_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bctrl(input int addr, input int ridx, input int data);
    return 16'(32768 + addr * 2048 + ridx * 256 + data);
  endfunction

  // register index and data per configuration event number
  function automatic int b_ridx(input int e);
    return (e == 0) ? 1 : (e == 1) ? 2 : 0;
  endfunction
  function automatic int b_data(input int e);
    return (e == 0) ? 27 : (e == 1) ? 7 : 128 + N;
  endfunction

  // transmit monitor
  logic [15:0] mw;
  int mbits = 0, mstart = 0;
  bit mcol = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_fs) begin
        if (mcol) chk(0, "R2", "frame sync inside a word", mbits, W);
        mcol = 1; mbits = 0; mstart = cyc; mw = '0;
      end
      if (mcol) begin
        mw = {mw[14:0], tx_sd};
        mbits++;
        if (mbits == W) begin
          txc_q.push_back(mstart); txw_q.push_back(mw); mcol = 0;
        end
      end
      for (int k = 0; k < N; k++)
        if (adc_valid[k]) begin
          ac_q.push_back(cyc); ach_q.push_back(k + 1);
          aw_q.push_back(adc_word[k*W +: W]);
        end
      if (cfg_done && done_cyc < 0) done_cyc = cyc;
      if (!cfg_done && done_cyc >= 0) chk(0, "R6", "cfg_done fell", 0, 1);
    end
  end

  task automatic send_event(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [N*W-1:0] dac, input int gap);
    logic [15:0] wv[N];
    int c;
    wv[0] = w0; wv[1] = w1;
    c = cyc;
    dac_word = dac;
    for (int s = 0; s < N; s++) begin
      exp_txc.push_back(c + 1 + s * W);
      if (ev_n < 3) exp_txw.push_back(bctrl(N - 1 - s, b_ridx(ev_n), b_data(ev_n)));
      else          exp_txw.push_back(dac[(N - 1 - s)*W +: W]);
      if (ev_n >= 3) begin
        exp_ac.push_back(c + s * W + W + 1);
        exp_ach.push_back(N - s);
        exp_aw.push_back(wv[s]);
      end
    end
    if (ev_n == 2) exp_done = c + N * W + 1;
    ev_n++;
    for (int s = 0; s < N; s++)
      for (int b = 0; b < W; b++) begin
        rx_fs = (b == 0);
        rx_sd = wv[s][W-1-b];
        @(negedge clk);
      end
    rx_fs = 0; rx_sd = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_fs == 0 && tx_sd == 0, "R1", "tx lines after reset", {tx_fs, tx_sd}, 0);
    chk(cfg_done == 0, "R1", "cfg_done after reset", cfg_done, 0);
    chk(adc_valid == 0 && adc_word == 0, "R1", "adc outputs after reset", adc_word, 0);
    mon_on = 1;
    // R4 R5: clock then power register events, with idle gaps
    send_event(16'hFFFF, 16'h8001, '1, 5);
    send_event(16'h1234, 16'hABCD, '0, 3);
    // R9 configuration words dropped
    chk(adc_word == 0, "R9", "adc_word during configuration", adc_word, 0);
    chk(ac_q.size() == 0, "R9", "valid pulses during configuration", ac_q.size(), 0);
    // R10 mode event followed with no gap by the first data event
    send_event(16'h5555, 16'hAAAA, {16'h1111, 16'h2222}, 0);
    send_event(16'h0000, 16'hFFFF, {16'hFFFF, 16'h0000}, 0);
    // R7 R8 random data events with mixed gaps
    for (int i = 0; i < 12; i++) begin
      send_event(16'($urandom), 16'($urandom), {16'($urandom), 16'($urandom)},
                 (i % 3 == 0) ? 0 : int'($urandom_range(1, 6)));
    end
    repeat (W + 6) @(negedge clk);
    // R2 R3 R4 R5 R7 transmit stream comparison
    chk(txw_q.size() == exp_txw.size(), "R2", "transmitted word count", txw_q.size(), exp_txw.size());
    for (int i = 0; i < exp_txw.size() && i < txw_q.size(); i++) begin
      chk(txc_q[i] == exp_txc[i], (i % N == 1) ? "R10" : "R2", "tx word start cycle", txc_q[i], exp_txc[i]);
      chk(txw_q[i] == exp_txw[i], (i < 3 * N) ? "R3/R4/R5" : "R7", "tx word value", txw_q[i], exp_txw[i]);
    end
    // R6
    chk(done_cyc == exp_done, "R6", "cfg_done rise cycle", done_cyc, exp_done);
    chk(cfg_done == 1, "R6", "cfg_done held", cfg_done, 1);
    // R8 R9 R11 received words
    chk(ac_q.size() == exp_ac.size(), "R9", "adc valid count", ac_q.size(), exp_ac.size());
    for (int i = 0; i < exp_ac.size() && i < ac_q.size(); i++) begin
      chk(ac_q[i] == exp_ac[i], "R8", "adc valid cycle", ac_q[i], exp_ac[i]);
      chk(ach_q[i] == exp_ach[i], "R8", "adc channel", ach_q[i], exp_ach[i]);
      chk(aw_q[i] == exp_aw[i], "R11", "adc word", aw_q[i], exp_aw[i]);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule